// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

The block drives and samples a set of general-purpose pins organised in banks of 32. Software reaches it over a simple 32-bit register bus with one-cycle write and read strobes. Every bank has its own direction, polarity-inversion and level registers. Output levels are changed only by write-one-to-set and write-one-to-clear registers, so one pin can be updated without a read-modify-write sequence.

Each input is brought into the clock domain through a two-flop synchroniser. Rising and falling transitions of the synchronised, polarity-adjusted level are detected per pin. A per-pin rising enable and a separate per-pin falling enable decide which transitions latch a sticky interrupt status bit, and software clears that bit by writing a one to it. A second sticky register logs every detected transition whether or not it is enabled. All banks share one interrupt output.

The register address is split into a group field in bits 7:4, which picks the register kind, and a bank field in bits 3:2. The registers of one kind for banks 0..3 therefore sit at a 4-byte stride.

Top module: `pinbank_gpio`

## Requirements
- R1: After reset every register reads 0: all pins are inputs (pin_oe_o all 0), no polarity inversion, output latches low, both interrupt enables clear, both status registers clear, and irq_o is low.
- R2: The register for bank n of a group is at group base + 4·n, and address bits 1:0 are ignored. The group bases are: direction 0x00, polarity 0x10, level 0x20, set 0x30, clear 0x40, rising enable 0x50, falling enable 0x60, interrupt status 0x90, edge log 0xA0. A bank index of NUM_BANKS or more reads 0, and writes to it change nothing. Bit i of every bank register belongs to pin 32·n+i.
- R3: A direction bit of 1 makes the pin an output, so pin_oe_o follows the direction register. A 0 makes the pin an input.
- R4: Writing the set register ORs the written ones into the output latch. Writing the clear register removes them. Zero bits leave the latch alone, and both registers read as 0.
- R5: The level register reads the output latch for output pins and the synchronised, polarity-adjusted input for input pins. Writes to the level register are ignored, and the pad input of an output pin does not show in it.
- R6: A polarity bit of 1 inverts the pad value of an output pin (pin_out_o = latch XOR polarity). For an input pin it inverts the level that is read and used for edge detection.
- R7: A 0→1 change of a pin's adjusted level sets its interrupt status bit when its rising enable is 1. A 1→0 change sets the bit when its falling enable is 1. With both enables at 0 the status bit never sets.
- R8: Writing 1 to an interrupt status bit clears it, and zero bits are unaffected. If an enabled edge and a clearing write reach the same bit in the same cycle, the bit stays set.
- R9: The edge log bit of a pin sets on every detected edge of its adjusted level, whatever its enables are, and clears on a write of 1.
- R10: irq_o is the OR over all banks of status bits whose rising or falling enable is set. An enabled edge at a pad shows on irq_o after the third rising clock edge that follows the pad change.
- R11: Read data is registered. bus_rdata_o shows the addressed register in the cycle after bus_rd_i and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe, one cycle per read |
| bus_addr_i | input | 8 | Byte address: group in 7:4, bank in 3:2 |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| pin_in_i | input | 32·NUM_BANKS | Asynchronous pad inputs |
| pin_out_o | output | 32·NUM_BANKS | Pad output values |
| pin_oe_o | output | 32·NUM_BANKS | Pad output enables, 1 = drive |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions assume one access per cycle, so a write and a read never target the status registers together. They also assume reset is held for at least one clock edge, which lets the $past comparisons start from known cleared state. The stimulus changes pad inputs only on falling clock edges, and it lets a polarity change settle for two cycles before clearing the edge log. The one intended collision is the clearing write that meets a fresh edge, which is timed exactly to the cycle in which the status bit would set.

// File: rtl/gpiob_pkg.sv
package gpiob_pkg;
    localparam int WORD_W = 32;

    // register group selectors, decoded from address bits 7:4
    typedef enum logic [3:0] {
        GRP_DIR   = 4'h0,
        GRP_POL   = 4'h1,
        GRP_LVL   = 4'h2,
        GRP_SET   = 4'h3,
        GRP_CLR   = 4'h4,
        GRP_RISE  = 4'h5,
        GRP_FALL  = 4'h6,
        GRP_ISTAT = 4'h9,
        GRP_ELOG  = 4'hA
    } grp_e;

    typedef struct packed {
        logic dir;
        logic pol;
        logic set;
        logic clr;
        logic rise;
        logic fall;
        logic istat;
        logic elog;
    } wr_strb_t;

    typedef struct packed {
        logic [WORD_W-1:0] dir;
        logic [WORD_W-1:0] pol;
        logic [WORD_W-1:0] outv;
        logic [WORD_W-1:0] rise_en;
        logic [WORD_W-1:0] fall_en;
        logic [WORD_W-1:0] istat;
        logic [WORD_W-1:0] elog;
        logic [WORD_W-1:0] prev;
    } bank_state_t;
endpackage

// File: rtl/gpiob_sync.sv
module gpiob_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/gpiob_bank.sv
module gpiob_bank
    import gpiob_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  wr_strb_t          wr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [WORD_W-1:0] sync_i,
    output logic [WORD_W-1:0] dir_o,
    output logic [WORD_W-1:0] pol_o,
    output logic [WORD_W-1:0] lvl_o,
    output logic [WORD_W-1:0] rise_o,
    output logic [WORD_W-1:0] fall_o,
    output logic [WORD_W-1:0] istat_o,
    output logic [WORD_W-1:0] elog_o,
    output logic [WORD_W-1:0] outv_o,
    output logic [WORD_W-1:0] pad_o,
    output logic              irq_o
);
    bank_state_t st_d, st_q;

    logic [WORD_W-1:0] adj_lvl;
    logic [WORD_W-1:0] rise_evt;
    logic [WORD_W-1:0] fall_evt;
    logic [WORD_W-1:0] flag_evt;
    logic [WORD_W-1:0] any_evt;
    logic [WORD_W-1:0] ist_clr;
    logic [WORD_W-1:0] elg_clr;

    always_comb begin
        // inversion applies on the input path only while the pin is an input
        adj_lvl  = sync_i ^ (st_q.pol & ~st_q.dir);
        rise_evt = adj_lvl & ~st_q.prev;
        fall_evt = ~adj_lvl & st_q.prev;
        flag_evt = (rise_evt & st_q.rise_en) | (fall_evt & st_q.fall_en);
        any_evt  = rise_evt | fall_evt;
        ist_clr  = wr_i.istat ? wdata_i : '0;
        elg_clr  = wr_i.elog  ? wdata_i : '0;

        st_d      = st_q;
        st_d.prev = adj_lvl;
        if (wr_i.dir)  st_d.dir     = wdata_i;
        if (wr_i.pol)  st_d.pol     = wdata_i;
        if (wr_i.rise) st_d.rise_en = wdata_i;
        if (wr_i.fall) st_d.fall_en = wdata_i;
        if (wr_i.set)  st_d.outv    = st_q.outv | wdata_i;
        if (wr_i.clr)  st_d.outv    = st_q.outv & ~wdata_i;
        // a fresh edge outranks a clearing write on the same bit
        st_d.istat = (st_q.istat & ~ist_clr) | flag_evt;
        st_d.elog  = (st_q.elog & ~elg_clr) | any_evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dir_o   = st_q.dir;
    assign pol_o   = st_q.pol;
    assign rise_o  = st_q.rise_en;
    assign fall_o  = st_q.fall_en;
    assign istat_o = st_q.istat;
    assign elog_o  = st_q.elog;
    assign outv_o  = st_q.outv;
    assign lvl_o   = (st_q.dir & st_q.outv) | (~st_q.dir & adj_lvl);
    assign pad_o   = st_q.outv ^ st_q.pol;
    assign irq_o   = |(st_q.istat & (st_q.rise_en | st_q.fall_en));
endmodule

// File: rtl/pinbank_gpio.sv
module pinbank_gpio
    import gpiob_pkg::*;
#(
    parameter int NUM_BANKS = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr_i,
    input  logic                        bus_rd_i,
    input  logic [7:0]                  bus_addr_i,
    input  logic [31:0]                 bus_wdata_i,
    output logic [31:0]                 bus_rdata_o,
    input  logic [NUM_BANKS*WORD_W-1:0] pin_in_i,
    output logic [NUM_BANKS*WORD_W-1:0] pin_out_o,
    output logic [NUM_BANKS*WORD_W-1:0] pin_oe_o,
    output logic                        irq_o
);
    localparam int ALL_W  = NUM_BANKS * WORD_W;
    localparam int BANK_W = 2;

    if (NUM_BANKS < 1 || NUM_BANKS > (1 << BANK_W)) begin : g_bad_cfg
        $error("NUM_BANKS out of range");
    end

    logic [3:0]        grp;
    logic [BANK_W-1:0] bank_sel;
    logic              unused_addr;

    assign grp         = bus_addr_i[7:4];
    assign bank_sel    = bus_addr_i[3:2];
    assign unused_addr = ^bus_addr_i[1:0];

    logic [ALL_W-1:0] pin_sync;
    logic [ALL_W-1:0] dir_all, pol_all, lvl_all, rise_all, fall_all;
    logic [ALL_W-1:0] istat_all, elog_all, outv_all, en_all;
    logic [NUM_BANKS-1:0] irq_b;

    gpiob_sync #(.W(ALL_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in_i),
        .sync_o  (pin_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic     hit;
        wr_strb_t strb;

        assign hit        = bus_wr_i && (bank_sel == BANK_W'(b));
        assign strb.dir   = hit && (grp == GRP_DIR);
        assign strb.pol   = hit && (grp == GRP_POL);
        assign strb.set   = hit && (grp == GRP_SET);
        assign strb.clr   = hit && (grp == GRP_CLR);
        assign strb.rise  = hit && (grp == GRP_RISE);
        assign strb.fall  = hit && (grp == GRP_FALL);
        assign strb.istat = hit && (grp == GRP_ISTAT);
        assign strb.elog  = hit && (grp == GRP_ELOG);

        gpiob_bank u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (strb),
            .wdata_i (bus_wdata_i),
            .sync_i  (pin_sync[b*WORD_W +: WORD_W]),
            .dir_o   (dir_all[b*WORD_W +: WORD_W]),
            .pol_o   (pol_all[b*WORD_W +: WORD_W]),
            .lvl_o   (lvl_all[b*WORD_W +: WORD_W]),
            .rise_o  (rise_all[b*WORD_W +: WORD_W]),
            .fall_o  (fall_all[b*WORD_W +: WORD_W]),
            .istat_o (istat_all[b*WORD_W +: WORD_W]),
            .elog_o  (elog_all[b*WORD_W +: WORD_W]),
            .outv_o  (outv_all[b*WORD_W +: WORD_W]),
            .pad_o   (pin_out_o[b*WORD_W +: WORD_W]),
            .irq_o   (irq_b[b])
        );
    end

    assign en_all   = rise_all | fall_all;
    assign pin_oe_o = dir_all;
    assign irq_o    = |irq_b;

    // read path: mux then register
    logic [31:0] rd_word;
    logic [31:0] rdata_d, rdata_q;

    always_comb begin
        rd_word = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_sel == BANK_W'(b)) begin
                case (grp)
                    GRP_DIR:   rd_word = dir_all[b*WORD_W +: WORD_W];
                    GRP_POL:   rd_word = pol_all[b*WORD_W +: WORD_W];
                    GRP_LVL:   rd_word = lvl_all[b*WORD_W +: WORD_W];
                    GRP_RISE:  rd_word = rise_all[b*WORD_W +: WORD_W];
                    GRP_FALL:  rd_word = fall_all[b*WORD_W +: WORD_W];
                    GRP_ISTAT: rd_word = istat_all[b*WORD_W +: WORD_W];
                    GRP_ELOG:  rd_word = elog_all[b*WORD_W +: WORD_W];
                    default:   rd_word = '0;
                endcase
            end
        end
        rdata_d = bus_rd_i ? rd_word : rdata_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/gpiob_chk.sv
module gpiob_chk #(
    parameter int NUM_BANKS = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_wr_i,
    input logic [7:0]              bus_addr_i,
    input logic [31:0]             bus_wdata_i,
    input logic [NUM_BANKS*32-1:0] pin_oe_o,
    input logic                    irq_o,
    input logic [NUM_BANKS*32-1:0] istat_all,
    input logic [NUM_BANKS*32-1:0] en_all,
    input logic [NUM_BANKS*32-1:0] outv_all
);
    // R3
    dir_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i[7:2] == 6'b000000) |=> (pin_oe_o[31:0] == $past(bus_wdata_i)));

    // R4
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i[7:2] == 6'b001100)
        |=> ((outv_all[31:0] & $past(bus_wdata_i)) == $past(bus_wdata_i)));

    // R4
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i[7:2] == 6'b010000)
        |=> ((outv_all[31:0] & $past(bus_wdata_i)) == 32'h0));

    // R7
    no_unenabled_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((istat_all & ~$past(istat_all) & ~$past(en_all)) == '0));

    // R10
    irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (istat_all == '0) |-> !irq_o);
endmodule

bind pinbank_gpio gpiob_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .pin_oe_o    (pin_oe_o),
    .irq_o       (irq_o),
    .istat_all   (istat_all),
    .en_all      (en_all),
    .outv_all    (outv_all)
);

// File: tb/pinbank_gpio_bench.sv
module pinbank_gpio_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_wr = 1'b0;
    logic           bus_rd = 1'b0;
    logic [7:0]     bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NB*32-1:0] pin_in = '0;
    logic [NB*32-1:0] pin_out;
    logic [NB*32-1:0] pin_oe;
    logic           irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_d = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pinbank_gpio #(.NUM_BANKS(NB)) u_pinbank_gpio (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr_i    (bus_wr),
        .bus_rd_i    (bus_rd),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .pin_in_i    (pin_in),
        .pin_out_o   (pin_out),
        .pin_oe_o    (pin_oe),
        .irq_o       (irq)
    );

    task automatic chk(input logic [63:0] got, input logic [63:0] exp, input string tag);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // monitor: a read issued before an edge is compared at the next falling edge (R11)
    always @(posedge clk) rd_d <= bus_rd;

    always @(negedge clk) begin
        if (rd_d) begin
            if (exp_q.size() == 0) begin
                chk(64'(bus_rdata), 64'hDEAD, "R11 unexpected read data");
            end else begin
                chk(64'(bus_rdata), 64'(exp_q.pop_front()), tag_q.pop_front());
            end
        end
    end

    // every task starts and ends just after a falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk(64'(pin_oe), 64'h0, "R1 pin_oe after reset");
        chk(64'(irq), 64'h0, "R1 irq after reset");
        rd(8'h00, 32'h0, "R1 direction reset");
        rd(8'h10, 32'h0, "R1 polarity reset");
        rd(8'h50, 32'h0, "R1 rise enable reset");
        rd(8'h90, 32'h0, "R1 status reset");

        // R3 / R2 direction and bank interleave
        wr(8'h00, 32'h0000_00FF);
        chk(64'(pin_oe[31:0]), 64'hFF, "R3 pin_oe bank0");
        wr(8'h04, 32'hF000_0000);
        chk(64'(pin_oe[63:32]), 64'hF000_0000, "R2 pin_oe bank1 at +4");

        // R4 set/clear
        wr(8'h30, 32'h0000_000F);
        chk(64'(pin_out[31:0]), 64'h0F, "R4 set drives high");
        rd(8'h20, 32'h0000_000F, "R4 level after set");
        wr(8'h40, 32'h0000_0005);
        rd(8'h20, 32'h0000_000A, "R4 level after clear");
        rd(8'h30, 32'h0, "R4 set reads zero");
        rd(8'h40, 32'h0, "R4 clear reads zero");

        // R5 level register
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, 32'h0000_000A, "R5 level write ignored");
        pin_in[31:0] = 32'h0000_0F01;
        idle(4);
        rd(8'h20, 32'h0000_0F0A, "R5 inputs and output latch");

        // R9 edge log records all edges
        rd(8'hA0, 32'h0000_0F01, "R9 edge log");
        wr(8'hA0, 32'hFFFF_FFFF);
        rd(8'hA0, 32'h0, "R9 edge log cleared");

        // R6 polarity
        wr(8'h10, 32'h0000_0101);
        chk(64'(pin_out[31:0]), 64'h10B, "R6 output inversion");
        idle(2);
        rd(8'h20, 32'h0000_0E0A, "R6 input inversion");
        wr(8'h10, 32'h0);
        idle(2);
        wr(8'hA0, 32'hFFFF_FFFF);

        // R7 / R10 rising and falling
        wr(8'h50, 32'h0000_1000);
        wr(8'h60, 32'h0000_2000);
        pin_in[13:12] = 2'b11;
        @(negedge clk);
        chk(64'(irq), 64'h0, "R10 irq one edge after pad");
        @(negedge clk);
        chk(64'(irq), 64'h0, "R10 irq two edges after pad");
        @(negedge clk);
        chk(64'(irq), 64'h1, "R10 irq three edges after pad");
        rd(8'h90, 32'h0000_1000, "R7 rising only where enabled");
        rd(8'hA0, 32'h0000_3000, "R9 both edges logged");
        wr(8'h90, 32'h0000_1000);
        chk(64'(irq), 64'h0, "R8 irq after clear");
        rd(8'h90, 32'h0, "R8 status cleared");

        pin_in[13:12] = 2'b00;
        idle(4);
        rd(8'h90, 32'h0000_2000, "R7 falling edge flagged");
        chk(64'(irq), 64'h1, "R10 irq on falling");
        wr(8'h90, 32'h0000_0001);
        rd(8'h90, 32'h0000_2000, "R8 zero bits unaffected");
        wr(8'h90, 32'h0000_2000);

        pin_in[14] = 1'b1;
        idle(4);
        pin_in[14] = 1'b0;
        idle(4);
        rd(8'h90, 32'h0, "R7 no enable no status");
        chk(64'(irq), 64'h0, "R7 no irq without enable");

        // R8 edge beats same-cycle clear
        pin_in[12] = 1'b1;
        idle(4);
        pin_in[12] = 1'b0;
        idle(4);
        rd(8'h90, 32'h0000_1000, "R8 setup status");
        pin_in[12] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr(8'h90, 32'h0000_1000);
        rd(8'h90, 32'h0000_1000, "R8 edge wins over clear");
        wr(8'h90, 32'h0000_1000);
        rd(8'h90, 32'h0, "R8 cleared afterwards");

        // R2 / R10 second bank
        wr(8'h54, 32'h0000_0001);
        pin_in[32] = 1'b1;
        idle(4);
        rd(8'h94, 32'h0000_0001, "R2 bank1 status");
        rd(8'h90, 32'h0, "R2 bank0 unaffected");
        chk(64'(irq), 64'h1, "R10 irq from bank1");
        wr(8'h94, 32'h0000_0001);
        chk(64'(irq), 64'h0, "R10 irq drops after bank1 clear");

        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, 32'h0, "R2 absent bank reads zero");
        chk(64'(pin_oe), 64'hF000_0000_0000_00FF, "R2 absent bank write ignored");
        rd(8'h03, 32'h0000_00FF, "R2 low address bits ignored");

        // R11 data holds without a read
        idle(2);
        chk(64'(bus_rdata), 64'hFF, "R11 read data held");

        idle(2);
        finish_run();
    end
endmodule